// File: doc/BRIEF.md
# Canonical Shift-Register Pointer Queue

This block is a small first-in first-out queue for fixed-width pointers, such as buffer addresses handed between a free-list and an output port. Storage is a chain of registers with valid entries kept packed at the head. A pop moves every entry one place toward the head. A push writes the new entry into the first slot behind the last valid one. Slots that hold no entry are forced to zero. Each possible queue content therefore has exactly one register state, which keeps the state space minimal for formal tools.

The user drives a push strobe with data and a pop strobe. The popped entry appears on a registered output in the cycle after the pop is accepted. The occupancy count and the full and empty flags are available every cycle. The depth is a parameter and may be zero. At depth zero no storage is built, the queue reads full and empty at the same time, and all traffic is discarded.

Top module: `canon_ptr_queue`

## Requirements
- R1: While reset is asserted and right after it, the count is 0, empty is 1, full is 0 (for depth above zero) and the pop data output is 0.
- R2: Entries leave in the order they were pushed. The pop data output takes the oldest entry on the clock edge that accepts the pop and holds it until the next accepted pop.
- R3: A push while the queue is full and no pop is requested is dropped. The count stays at the depth and the stored entries are unchanged, as later pops show.
- R4: A push together with a pop on a full queue is accepted. The oldest entry leaves, the new entry joins at the tail, and the queue stays full.
- R5: A pop on an empty queue is ignored. The count stays 0 and the pop data output keeps its previous value.
- R6: The count equals the number of stored entries and never exceeds the depth. Full is 1 exactly when the count equals the depth, and empty is 1 exactly when the count is 0.
- R7: For any push/pop sequence, the outputs match those of an array managed by head and tail pointers and an element counter of the same depth. Storage slots at or beyond the count hold zero, so each content has a single state.
- R8: With depth zero, full and empty are both 1 at all times, the count is 0, every push is dropped, and the pop data output stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request |
| push_data_i | input | W | Pointer to enqueue |
| pop_i | input | 1 | Pop request |
| pop_data_o | output | W | Most recently popped pointer (registered) |
| count_o | output | CW (clog2(DEPTH+1), at least 1) | Number of stored entries |
| full_o | output | 1 | Queue holds DEPTH entries (always 1 at depth zero) |
| empty_o | output | 1 | Queue holds no entries (always 1 at depth zero) |

## Verification
The embedded properties check, on every cycle, that the count stays within bounds and moves by at most one. They also check that drops on a full queue leave the count alone, that a swap on a full queue keeps it full, that ignored pops leave the output stable, and that every slot at or beyond the count is zero. Ordering cannot be shown by any of these properties. Correct contents after a dropped push, and equivalence with a pointer-managed array, only come out of the bench's scenarios. There, directed fills, drains and swaps plus seeded random traffic are compared against an independent head/tail model, and a depth-zero instance runs beside the main one.

// File: rtl/cpq_pkg.sv
package cpq_pkg;

  // Width of an occupancy counter able to hold 0..depth (at least one bit).
  function automatic int cnt_w(input int depth);
    if (depth < 1) return 1;
    return $clog2(depth + 1);
  endfunction

  // Occupancy after one cycle, given the accepted operations.
  function automatic int next_occupancy(input int occ, input bit push_ok, input bit pop_ok);
    return occ + (push_ok ? 1 : 0) - (pop_ok ? 1 : 0);
  endfunction

endpackage

// File: rtl/cpq_ctrl.sv
module cpq_ctrl #(
  parameter int DEPTH = 4,
  parameter int CW    = cpq_pkg::cnt_w(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [CW-1:0] after_pop,
  output logic [CW-1:0] count_q,
  output logic          full,
  output logic          empty
);
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

  logic [CW-1:0] count_d;

  assign empty     = (count_q == '0);
  assign full      = (count_q == LIMIT);
  assign pop_ok    = pop_i && !empty;
  assign push_ok   = push_i && (!full || pop_ok);
  assign after_pop = count_q - CW'(pop_ok);
  assign count_d   = CW'(cpq_pkg::next_occupancy(int'(count_q), push_ok, pop_ok));

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  // R6: occupancy never passes the depth
  a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= LIMIT);

  // R6: occupancy moves by at most one per cycle
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ((count_q == $past(count_q)) || (count_q == $past(count_q) + CW'(1)) ||
         (count_q + CW'(1) == $past(count_q))));

  // R3: push into a full queue without pop leaves the occupancy alone
  a_r3_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full) |=> (count_q == LIMIT));

  // R4: push with pop on a full queue keeps it full
  a_r4_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && full) |=> full);

endmodule

// File: rtl/cpq_slot.sv
module cpq_slot #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         keep,
  input  logic         load_new,
  input  logic         shift_en,
  input  logic [W-1:0] new_data,
  input  logic [W-1:0] shift_in,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  always_comb begin
    if (!keep)         d = '0;
    else if (load_new) d = new_data;
    else if (shift_en) d = shift_in;
    else               d = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/canon_ptr_queue.sv
module canon_ptr_queue #(
  parameter int W     = 4,
  parameter int DEPTH = 4,
  localparam int CW   = cpq_pkg::cnt_w(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [W-1:0]  push_data_i,
  input  logic          pop_i,
  output logic [W-1:0]  pop_data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);

  generate
    if (DEPTH == 0) begin : g_null
      logic unused_inputs;
      assign unused_inputs = ^{push_i, push_data_i, pop_i};
      assign pop_data_o = '0;
      assign count_o    = '0;
      assign full_o     = 1'b1;
      assign empty_o    = 1'b1;

      // R8: a null queue always reads full and empty
      a_r8_null: assert property (@(posedge clk) disable iff (!rst_n)
        full_o && empty_o && (pop_data_o == '0));
    end else begin : g_live
      logic          push_ok, pop_ok, full, empty;
      logic [CW-1:0] after_pop, count_q, count_next;
      logic [W-1:0]  slot_q [DEPTH];
      logic [W-1:0]  data_q;

      cpq_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .push_ok(push_ok), .pop_ok(pop_ok), .after_pop(after_pop),
        .count_q(count_q), .full(full), .empty(empty)
      );

      assign count_next = after_pop + CW'(push_ok);

      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [W-1:0] nxt;
        if (g == DEPTH - 1) begin : g_tail
          assign nxt = '0;
        end else begin : g_mid
          assign nxt = slot_q[g+1];
        end

        cpq_slot #(.W(W)) u_slot (
          .clk(clk), .rst_n(rst_n),
          .keep(CW'(g) < count_next),
          .load_new(push_ok && (CW'(g) == after_pop)),
          .shift_en(pop_ok),
          .new_data(push_data_i),
          .shift_in(nxt),
          .q(slot_q[g])
        );

        // R7: empty positions hold zero, so the state is canonical
        a_r7_canon: assert property (@(posedge clk) disable iff (!rst_n)
          (CW'(g) >= count_q) |-> (slot_q[g] == '0));
      end

      always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (pop_ok) data_q <= slot_q[0];
      end

      assign pop_data_o = data_q;
      assign count_o    = count_q;
      assign full_o     = full;
      assign empty_o    = empty;

      // R5: a pop on an empty queue leaves the output untouched
      a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o) |=> $stable(pop_data_o));
    end
  endgenerate

endmodule

// File: tb/canon_ptr_queue_test.sv
module canon_ptr_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push = 1'b0, pop = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout, dout_z;
  logic [2:0] cnt;
  logic [0:0] cnt_z;
  logic full, empty, full_z, empty_z;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  canon_ptr_queue #(.W(W), .DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .push_i(push), .push_data_i(din), .pop_i(pop),
    .pop_data_o(dout), .count_o(cnt), .full_o(full), .empty_o(empty));

  canon_ptr_queue #(.W(W), .DEPTH(0)) uut_z (
    .clk(clk), .rst_n(rst_n), .push_i(push), .push_data_i(din), .pop_i(pop),
    .pop_data_o(dout_z), .count_o(cnt_z), .full_o(full_z), .empty_o(empty_z));

  // Reference: array with head/tail pointers and an element counter
  logic [W-1:0] mem [D];
  int hd = 0, tl = 0, occ = 0;
  logic [W-1:0] exp_out = '0;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " count"}, int'(cnt), occ);
    chk({tag, " full"}, int'(full), int'(occ == D));
    chk({tag, " empty"}, int'(empty), int'(occ == 0));
    chk({tag, " data"}, int'(dout), int'(exp_out));
    // R8: zero-depth instance sees the same traffic
    chk("R8 null flags", int'({full_z, empty_z}), 3);
    chk("R8 null count", int'(cnt_z), 0);
    chk("R8 null data", int'(dout_z), 0);
  endtask

  task automatic step(input bit pu, input logic [W-1:0] d, input bit po, input string tag);
    bit pop_take, push_take;
    push = pu; din = d; pop = po;
    @(posedge clk);
    pop_take  = po && (occ > 0);
    push_take = pu && ((occ < D) || pop_take);
    if (pop_take) begin
      exp_out = mem[hd];
      hd = (hd + 1) % D;
      occ--;
    end
    if (push_take) begin
      mem[tl] = d;
      tl = (tl + 1) % D;
      occ++;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    step(0, 4'h0, 0, "R1 idle");

    // R5: pop on empty with nothing ever popped
    step(0, 4'h0, 1, "R5 pop empty");

    // R2/R6: fill to full with distinct values
    step(1, 4'h3, 0, "R6 fill");
    step(1, 4'h9, 0, "R6 fill");
    step(1, 4'hC, 0, "R6 fill");
    step(1, 4'h5, 0, "R6 fill full");

    // R3: pushes into full queue are dropped
    step(1, 4'hF, 0, "R3 drop");
    step(1, 4'hE, 0, "R3 drop");

    // R4: simultaneous push and pop on full queue
    step(1, 4'hA, 1, "R4 swap");
    step(1, 4'h1, 1, "R4 swap");

    // R2/R3: drain and confirm order with no dropped value present
    step(0, 4'h0, 1, "R2 drain");
    step(0, 4'h0, 1, "R2 drain");
    step(0, 4'h0, 1, "R2 drain");
    step(0, 4'h0, 1, "R2 drain");

    // R5: pop on empty keeps last popped value
    step(0, 4'h0, 1, "R5 pop empty hold");
    step(1, 4'h7, 1, "R5 push while pop empty");
    step(0, 4'h0, 1, "R2 single");

    // R7: seeded random traffic against the pointer model
    void'($urandom(32'h1234));
    for (int n = 0; n < 2000; n++) begin
      bit pu, po;
      logic [W-1:0] d;
      pu = ($urandom % 100) < 55;
      po = ($urandom % 100) < 45;
      d  = W'($urandom);
      step(pu, d, po, "R7 random");
    end

    // R6: reach full again then empty through random-free drain
    for (int n = 0; n < D + 1; n++) step(1, W'(n + 2), 0, "R6 refill");
    for (int n = 0; n < D + 1; n++) step(0, 4'h0, 1, "R6 redrain");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule